// File: doc/BRIEF.md
# Bit-Slice Integer ALU with Signed Compare

This block is a purely combinational integer arithmetic-logic unit. It is built by repeating a one-bit slice once per operand bit. Every slice carries four pieces of logic:

- an AND gate;
- an OR gate;
- a full adder whose B input can be inverted;
- a four-way result selector.

The slices are chained through their carries, so the adder ripples from bit 0 upward. A 3-bit operation code selects one of five functions on two operand words:

- bitwise AND;
- bitwise OR;
- addition;
- subtraction;
- signed set-on-less-than.

Besides the result word, the block reports three flags: a zero flag, a signed-overflow flag and the carry leaving the top slice.

Subtraction has no separate datapath. A single invert-B control line flips the B input of every slice and also feeds the carry-in of bit 0, so the adder forms a + ~b + 1. The signed compare runs that subtraction and takes the sign of the difference from the top slice. It corrects that sign by the overflow condition and routes the outcome back into bit 0 of the result through a dedicated less-than input. An equality test is done by subtracting and reading the zero flag.

Top module: `bitslice_alu`

## Requirements
- R1: Operation code 3'b000 drives the result with the bitwise AND of the operands.
- R2: Operation code 3'b001 drives the result with the bitwise OR of the operands.
- R3: Operation code 3'b010 drives the result with a + b, truncated to the operand width.
- R4: Operation code 3'b110 drives the result with a - b, computed as a + ~b + 1 and truncated to the operand width.
- R5: Operation code 3'b111 sets result bit 0 to 1 when a is less than b as two's-complement numbers, and to 0 otherwise. All higher result bits are 0. The comparison stays correct when the internal subtraction overflows.
- R6: The zero flag is 1 exactly when every result bit is 0, for every operation code.
- R7: Under addition, the overflow flag is 1 exactly when both operands have the same sign bit and the result's sign bit differs from it.
- R8: Under subtraction, the overflow flag is 1 exactly when the operands' sign bits differ and the result's sign bit differs from a's.
- R9: Under addition and subtraction, the carry flag equals the carry out of the top slice, which is bit 32 of the 33-bit sum a + b or a + ~b + 1. It is 0 for AND, OR and set-on-less-than.
- R10: The overflow flag is 0 for AND, OR and set-on-less-than.
- R11: The unused codes 3'b011, 3'b100 and 3'b101 give an all-zero result with the overflow and carry flags at 0, so the zero flag reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a_i | input | 32 | First operand (minuend for subtraction and compare) |
| opnd_b_i | input | 32 | Second operand |
| op_i | input | 3 | Operation code |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow of an add or subtract |
| carry_o | output | 1 | Carry out of the top slice for add and subtract |

## Verification
The bench aims at operand pairs where the compare and the flags are easiest to get wrong.

- The most-negative and most-positive words, compared against each other and against small values: here the subtraction overflows. A compare that reads the raw sign bit would return the inverted answer, such as claiming 0x80000000 is not below 1.
- Sums that wrap past the top bit, and differences of equal operands: these check that the carry comes from the top slice only for arithmetic codes, and that the zero flag tracks equality.
- Mixed-sign and same-sign additions: an overflow detector built from the wrong pair of sign bits fires on safe opposite-sign adds.
- The three unused codes: a result selector that falls through to the adder or OR path leaks non-zero data on these codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam logic [2:0] OP_AND  = 3'b000;
    localparam logic [2:0] OP_OR   = 3'b001;
    localparam logic [2:0] OP_ADD  = 3'b010;
    localparam logic [2:0] OP_SUB  = 3'b110;
    localparam logic [2:0] OP_SLT  = 3'b111;

    typedef enum logic [1:0] {
        SEL_AND  = 2'd0,
        SEL_OR   = 2'd1,
        SEL_SUM  = 2'd2,
        SEL_LESS = 2'd3
    } slice_sel_e;

    typedef struct packed {
        logic       enable;    // slices drive their selected value
        logic       invert_b;  // flip B in every slice and carry 1 into bit 0
        logic       arith;     // add or subtract: flags are reported
        slice_sel_e sel;       // per-slice result selector
    } alu_ctl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [2:0] op_i,
    output alu_ctl_t   ctl_o
);

    alu_ctl_t ctl_d;

    always_comb begin
        ctl_d = '{enable: 1'b0, invert_b: 1'b0, arith: 1'b0, sel: SEL_AND};
        case (op_i)
            OP_AND: ctl_d = '{enable: 1'b1, invert_b: 1'b0, arith: 1'b0, sel: SEL_AND};
            OP_OR:  ctl_d = '{enable: 1'b1, invert_b: 1'b0, arith: 1'b0, sel: SEL_OR};
            OP_ADD: ctl_d = '{enable: 1'b1, invert_b: 1'b0, arith: 1'b1, sel: SEL_SUM};
            OP_SUB: ctl_d = '{enable: 1'b1, invert_b: 1'b1, arith: 1'b1, sel: SEL_SUM};
            OP_SLT: ctl_d = '{enable: 1'b1, invert_b: 1'b1, arith: 1'b0, sel: SEL_LESS};
            default: ctl_d = '{enable: 1'b0, invert_b: 1'b0, arith: 1'b0, sel: SEL_AND};
        endcase
    end

    assign ctl_o = ctl_d;

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       cin_i,
    input  logic       invert_b_i,
    input  logic       less_i,
    input  logic       enable_i,
    input  slice_sel_e sel_i,
    output logic       res_o,
    output logic       sum_o,
    output logic       cout_o
);

    logic b_eff_d;
    logic sum_d;
    logic cout_d;
    logic res_d;

    always_comb begin
        b_eff_d = b_i ^ invert_b_i;
        sum_d   = a_i ^ b_eff_d ^ cin_i;
        cout_d  = (a_i & b_eff_d) | (a_i & cin_i) | (b_eff_d & cin_i);
        unique case (sel_i)
            SEL_AND:  res_d = a_i & b_i;
            SEL_OR:   res_d = a_i | b_i;
            SEL_SUM:  res_d = sum_d;
            SEL_LESS: res_d = less_i;
            default:  res_d = 1'b0;
        endcase
        res_d = res_d & enable_i;
    end

    assign res_o  = res_d;
    assign sum_o  = sum_d;
    assign cout_o = cout_d;

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res_i,
    input  logic             top_cin_i,
    input  logic             top_cout_i,
    input  logic             top_sum_i,
    input  logic             arith_i,
    output logic             zero_o,
    output logic             ovf_o,
    output logic             carry_o,
    output logic             set_o
);

    logic raw_ovf_d;

    always_comb begin
        raw_ovf_d = top_cin_i ^ top_cout_i;
        set_o     = top_sum_i ^ raw_ovf_d;
        ovf_o     = arith_i & raw_ovf_d;
        carry_o   = arith_i & top_cout_i;
        zero_o    = ~|res_i;
    end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a_i,
    input  logic [WIDTH-1:0] opnd_b_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             ovf_o,
    output logic             carry_o
);

    localparam int MSB = WIDTH - 1;

    alu_ctl_t         ctl_d;
    logic [WIDTH:0]   carry_d;
    logic [WIDTH-1:0] res_d;
    logic [WIDTH-1:0] sum_d;
    logic             set_d;

    alu_op_decode u_dec (
        .op_i  (op_i),
        .ctl_o (ctl_d)
    );

    assign carry_d[0] = ctl_d.invert_b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_d;
        if (i == 0) begin : g_lsb
            assign less_d = set_d;
        end else begin : g_upper
            assign less_d = 1'b0;
        end
        alu_bit_slice u_slice (
            .a_i        (opnd_a_i[i]),
            .b_i        (opnd_b_i[i]),
            .cin_i      (carry_d[i]),
            .invert_b_i (ctl_d.invert_b),
            .less_i     (less_d),
            .enable_i   (ctl_d.enable),
            .sel_i      (ctl_d.sel),
            .res_o      (res_d[i]),
            .sum_o      (sum_d[i]),
            .cout_o     (carry_d[i+1])
        );
    end

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .res_i      (res_d),
        .top_cin_i  (carry_d[MSB]),
        .top_cout_i (carry_d[WIDTH]),
        .top_sum_i  (sum_d[MSB]),
        .arith_i    (ctl_d.arith),
        .zero_o     (zero_o),
        .ovf_o      (ovf_o),
        .carry_o    (carry_o),
        .set_o      (set_d)
    );

    assign result_o = res_d;

    always_comb begin
        // R3
        arith_path_chk: assert (!ctl_d.arith || res_d == sum_d);
        // R5
        slt_upper_chk: assert (op_i != OP_SLT || res_d[MSB:1] == '0);
        // R5
        slt_value_chk: assert (op_i != OP_SLT ||
                               res_d[0] == ($signed(opnd_a_i) < $signed(opnd_b_i)));
        // R7
        add_ovf_chk: assert (op_i != OP_ADD || !ovf_o ||
                             (opnd_a_i[MSB] == opnd_b_i[MSB] && res_d[MSB] != opnd_a_i[MSB]));
        // R8
        sub_ovf_chk: assert (op_i != OP_SUB || !ovf_o ||
                             (opnd_a_i[MSB] != opnd_b_i[MSB] && res_d[MSB] != opnd_a_i[MSB]));
        // R10
        logic_flags_chk: assert (ctl_d.arith || (!ovf_o && !carry_o));
        // R11
        unused_code_chk: assert (ctl_d.enable || (res_d == '0 && zero_o));
    end

endmodule

// File: tb/sim_bitslice_alu.sv
module sim_bitslice_alu;

    logic        clk = 1'b0;
    logic [31:0] a, b;
    logic [2:0]  op;
    logic [31:0] res;
    logic        zero, ovf, cout;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    bitslice_alu u0 (
        .opnd_a_i (a),
        .opnd_b_i (b),
        .op_i     (op),
        .result_o (res),
        .zero_o   (zero),
        .ovf_o    (ovf),
        .carry_o  (cout)
    );

    localparam int NV = 18;
    localparam logic [2:0] VOP [NV] = '{
        3'b000, 3'b001, 3'b010, 3'b010, 3'b010, 3'b010,
        3'b110, 3'b110, 3'b110, 3'b110, 3'b111, 3'b111,
        3'b111, 3'b111, 3'b111, 3'b011, 3'b100, 3'b101};
    localparam logic [31:0] VA [NV] = '{
        32'hF0F0_A5A5, 32'h0F00_1234, 32'h7FFF_FFFF, 32'hFFFF_FFFF,
        32'h8000_0000, 32'h0000_0007, 32'h0000_0007, 32'h8000_0000,
        32'h7FFF_FFFF, 32'h1234_5678, 32'h8000_0000, 32'h7FFF_FFFF,
        32'hFFFF_FFFF, 32'h0000_0005, 32'h8000_0000, 32'hFFFF_FFFF,
        32'h1234_5678, 32'hAAAA_AAAA};
    localparam logic [31:0] VB [NV] = '{
        32'hFF00_0FF0, 32'h00F0_0001, 32'h0000_0001, 32'h0000_0001,
        32'h8000_0000, 32'hFFFF_FFFA, 32'h0000_0006, 32'h0000_0001,
        32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0001, 32'h8000_0000,
        32'h0000_0000, 32'h0000_0005, 32'h7FFF_FFFF, 32'h0000_0001,
        32'h1111_1111, 32'h5555_5555};

    function automatic logic [34:0] ref_alu(input logic [2:0] o,
                                            input logic [31:0] x,
                                            input logic [31:0] y);
        logic [32:0] s;
        logic [31:0] r;
        logic v, c;
        r = '0; v = 1'b0; c = 1'b0;
        case (o)
            3'b000: r = x & y;
            3'b001: r = x | y;
            3'b010: begin
                s = {1'b0, x} + {1'b0, y};
                r = s[31:0]; c = s[32];
                v = (x[31] == y[31]) && (r[31] != x[31]);
            end
            3'b110: begin
                s = {1'b0, x} + {1'b0, ~y} + 33'd1;
                r = s[31:0]; c = s[32];
                v = (x[31] != y[31]) && (r[31] != x[31]);
            end
            3'b111: r = {31'd0, $signed(x) < $signed(y)};
            default: r = '0;
        endcase
        return {r, (r == 32'd0), v, c};
    endfunction

    function automatic string op_tag(input logic [2:0] o);
        case (o)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b110: return "R4";
            3'b111: return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic check_bit(input string tag, input string what,
                             input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: op=%b a=%h b=%h actual=%b expected=%b",
                     tag, what, op, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [34:0] e;
        string ftag;
        @(posedge clk);
        op = o; a = x; b = y;
        @(negedge clk);
        e = ref_alu(o, x, y);
        n_run++;
        if (res !== e[34:3]) begin
            n_fail++;
            $display("FAIL %s result: op=%b a=%h b=%h actual=%h expected=%h",
                     op_tag(o), o, x, y, res, e[34:3]);
        end
        // R6
        check_bit("R6", "zero", zero, e[2]);
        ftag = (o == 3'b010) ? "R7" : (o == 3'b110) ? "R8" : "R10";
        check_bit(ftag, "overflow", ovf, e[1]);
        // R9
        check_bit("R9", "carry", cout, e[0]);
    endtask

    initial begin
        a = '0; b = '0; op = 3'b000;
        @(negedge clk);
        // Idle inputs: AND of zeros gives zero result, R6 zero flag set
        check_bit("R1", "idle result zero", res == 32'd0, 1'b1);
        check_bit("R6", "idle zero flag", zero, 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VOP[i], VA[i], VB[i]);
        end

        // R4 and R6: equality via subtract
        apply(3'b110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        // R5: overflowing compare both ways
        apply(3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        apply(3'b111, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
        // R7: opposite signs never overflow
        apply(3'b010, 32'h8000_0000, 32'h7FFF_FFFF);
        // R11: all unused codes with all-ones operands
        apply(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply(3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply(3'b101, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] x, y;
            x = $urandom;
            y = $urandom;
            if (i % 5 == 0) y = x;
            if (i % 7 == 0) x[31] = ~y[31];
            apply(3'($urandom_range(0, 7)), x, y);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule